// File: doc/BRIEF.md
# Per-Instruction Stride Prefetcher

This block observes the stream of retiring loads and learns, separately for each load instruction, whether the addresses it touches advance by a fixed step. A small direct-mapped history table keyed by the instruction pointer keeps the last address, the last step and a 2-bit confidence count for each tracked instruction. When an instruction repeats its step often enough, the block predicts the next address. It asks the cache whether that 64-byte line is already present, using a combinational probe port. When the line is absent, the block queues a prefetch request.

Queued requests go to the lower-level memory bus, but only in cycles when demand traffic leaves the bus free. Returned lines are written to a small prefetch buffer kept apart from the cache, so a wrong guess never evicts useful cache data. A response flagged as faulting, such as one for an unmapped page, is discarded without any trace. The load path can ask the buffer whether it holds a given line.

Top module: `stride_prefetcher`

## Requirements
- R1: After reset no probe or bus request is raised, the history table holds no entry, and the prefetch buffer reports a miss for every line.
- R2: The table has 16 entries. The entry is selected by instruction pointer bits [3:0], and the remaining bits form its tag. A probe is raised in the load cycle with `probe_line_o` = (load address + stride) >> 6. This happens only when the stride equals the stored stride and the updated confidence reaches 2, which is on the third consecutive equal nonzero stride.
- R3: A stride that differs from the stored stride clears confidence and stores the new stride. Prediction then needs two further equal strides.
- R4: A zero stride never raises a probe, however often it repeats.
- R5: A load whose tag differs from the tag in its selected entry replaces that entry and does not predict from the old contents.
- R6: When `probe_hit_i` is high during a probe, no request is queued.
- R7: A probe whose line equals a line already in the request queue is dropped.
- R8: The request queue holds 4 lines. A probe arriving when the queue is full is dropped.
- R9: `bus_req_o` is high only in cycles where `bus_busy_i` is low. Queued lines leave in arrival order, one per cycle.
- R10: A response with `rsp_fault_i` low stores its line in the prefetch buffer. `look_hit_o` is then high for that line.
- R11: A response with `rsp_fault_i` high leaves the buffer unchanged.
- R12: The buffer holds 4 lines and replaces the oldest stored line first.
- R13: Negative strides work with wrap-around address arithmetic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ld_valid_i | input | 1 | A load retires this cycle |
| ld_ip_i | input | 32 | Instruction pointer of the load |
| ld_addr_i | input | 32 | Byte address of the load |
| probe_valid_o | output | 1 | Predicted line is being checked against the cache |
| probe_line_o | output | 26 | Predicted line address (byte address >> 6) |
| probe_hit_i | input | 1 | Cache holds the probed line (same cycle) |
| bus_busy_i | input | 1 | Demand traffic owns the lower-level bus |
| bus_req_o | output | 1 | Prefetch request issued this cycle |
| bus_line_o | output | 26 | Line address of the issued request |
| rsp_valid_i | input | 1 | Prefetch response arrives |
| rsp_line_i | input | 26 | Line address of the response |
| rsp_fault_i | input | 1 | Response raised a fault and must be dropped |
| look_line_i | input | 26 | Line address looked up in the prefetch buffer |
| look_hit_o | output | 1 | Prefetch buffer holds `look_line_i` |

## Verification
The hardest states to reach are a full request queue and a duplicate request. Both need several independent instructions to be trained while the queue is unable to drain. The stimulus therefore holds `bus_busy_i` high for the whole training walk. It trains a second instruction to predict a line that is already queued, then fills the queue with two more streams, one of them descending, and fires one more prediction into the full queue. Releasing the bus afterwards shows the exact drain order, which proves that the duplicate and the overflow were both dropped.

// File: rtl/spf_pkg.sv
package spf_pkg;
  localparam int unsigned LINE_OFS_W = 6;  // 64-byte lines

  typedef enum logic [1:0] {
    CONF_NONE = 2'd0,
    CONF_LOW  = 2'd1,
    CONF_MID  = 2'd2,
    CONF_HIGH = 2'd3
  } conf_e;
endpackage

// File: rtl/spf_hist_table.sv
module spf_hist_table
  import spf_pkg::*;
#(
  parameter int unsigned IP_W    = 32,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [IP_W-1:0]   ld_ip_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              pred_valid_o,
  output logic [ADDR_W-1:0] pred_addr_o
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = IP_W - IDX_W;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  last_q   [ENTRIES];
  logic [ADDR_W-1:0]  stride_q [ENTRIES];
  conf_e              conf_q   [ENTRIES];

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              hit, same;
  logic [ADDR_W-1:0] new_stride;
  conf_e             conf_next;

  always_comb begin
    idx        = ld_ip_i[IDX_W-1:0];
    tag        = ld_ip_i[IP_W-1:IDX_W];
    hit        = vld_q[idx] && (tag_q[idx] == tag);
    new_stride = ld_addr_i - last_q[idx];
    same       = hit && (new_stride == stride_q[idx]);
    if (!same)                        conf_next = CONF_NONE;
    else if (conf_q[idx] == CONF_HIGH) conf_next = CONF_HIGH;
    else                              conf_next = conf_e'(conf_q[idx] + 2'd1);
    pred_valid_o = ld_valid_i && same && (new_stride != '0) && (conf_next >= CONF_MID);
    pred_addr_o  = ld_addr_i + new_stride;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         vld_q      <= '0;
    else if (ld_valid_i) vld_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (ld_valid_i) begin
      tag_q[idx]    <= tag;
      last_q[idx]   <= ld_addr_i;
      stride_q[idx] <= hit ? new_stride : '0;
      conf_q[idx]   <= conf_next;
    end
  end

  // R2
  conf_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (vld_q[idx] && conf_q[idx] != CONF_NONE));

  // R4
  zero_stride_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_valid_o |-> (pred_addr_o != ld_addr_i));
endmodule

// File: rtl/spf_req_queue.sv
module spf_req_queue #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned DEPTH  = 4   // power of two
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [LINE_W-1:0] push_line_i,
  input  logic              busy_i,
  output logic              req_o,
  output logic [LINE_W-1:0] req_line_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic              dup, full, push_ok;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && line_q[i] == push_line_i) dup = 1'b1;
    full       = &vld_q;
    push_ok    = push_i && !dup && !full;
    req_o      = vld_q[rd_q] && !busy_i;
    req_line_o = line_q[rd_q];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wr_q  <= '0;
      rd_q  <= '0;
    end else begin
      if (req_o) begin
        vld_q[rd_q] <= 1'b0;
        rd_q        <= rd_q + 1'b1;
      end
      if (push_ok) begin
        vld_q[wr_q] <= 1'b1;
        wr_q        <= wr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) line_q[wr_q] <= push_line_i;
  end

  // R7
  dup_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && dup && !req_o) |=> $stable(vld_q));

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && push_i && !req_o) |=> $stable(vld_q));

  // R9
  pop_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !push_ok) |=> ($countones(vld_q) == $countones($past(vld_q)) - 1));
endmodule

// File: rtl/spf_line_buffer.sv
module spf_line_buffer #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned DEPTH  = 4   // power of two
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_i,
  input  logic [LINE_W-1:0] fill_line_i,
  input  logic              fault_i,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              hit_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  vld_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [PTR_W-1:0]  wp_q;
  logic              fill_ok;

  assign fill_ok = fill_i && !fault_i;

  always_comb begin
    hit_o = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (vld_q[i] && line_q[i] == look_line_i) hit_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      wp_q  <= '0;
    end else if (fill_ok) begin
      vld_q[wp_q] <= 1'b1;
      wp_q        <= wp_q + 1'b1;  // oldest slot is next
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_ok) line_q[wp_q] <= fill_line_i;
  end

  // R11
  fault_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && fault_i) |=> ($stable(vld_q) && $stable(wp_q)));
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher
  import spf_pkg::*;
#(
  parameter int unsigned IP_W      = 32,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned ENTRIES   = 16,
  parameter int unsigned Q_DEPTH   = 4,
  parameter int unsigned BUF_DEPTH = 4,
  localparam int unsigned LINE_W   = ADDR_W - LINE_OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_valid_i,
  input  logic [IP_W-1:0]   ld_ip_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              probe_valid_o,
  output logic [LINE_W-1:0] probe_line_o,
  input  logic              probe_hit_i,
  input  logic              bus_busy_i,
  output logic              bus_req_o,
  output logic [LINE_W-1:0] bus_line_o,
  input  logic              rsp_valid_i,
  input  logic [LINE_W-1:0] rsp_line_i,
  input  logic              rsp_fault_i,
  input  logic [LINE_W-1:0] look_line_i,
  output logic              look_hit_o
);
  logic [ADDR_W-1:0] pred_addr;

  spf_hist_table #(.IP_W(IP_W), .ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk_i, .rst_ni, .ld_valid_i, .ld_ip_i, .ld_addr_i,
    .pred_valid_o(probe_valid_o), .pred_addr_o(pred_addr)
  );

  assign probe_line_o = pred_addr[ADDR_W-1:LINE_OFS_W];

  spf_req_queue #(.LINE_W(LINE_W), .DEPTH(Q_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .push_i(probe_valid_o && !probe_hit_i), .push_line_i(probe_line_o),
    .busy_i(bus_busy_i), .req_o(bus_req_o), .req_line_o(bus_line_o)
  );

  spf_line_buffer #(.LINE_W(LINE_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk_i, .rst_ni,
    .fill_i(rsp_valid_i), .fill_line_i(rsp_line_i), .fault_i(rsp_fault_i),
    .look_line_i, .hit_o(look_hit_o)
  );

  // R6
  cache_hit_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (probe_valid_o && probe_hit_i && !bus_req_o && !u_queue.vld_q[u_queue.wr_q])
      |=> $stable(u_queue.vld_q));
endmodule

// File: tb/sim_stride_prefetcher.sv
`timescale 1ns/1ps
module sim_stride_prefetcher;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_ip_i = '0, ld_addr_i = '0;
  logic        probe_valid_o, probe_hit_i = 1'b0;
  logic [25:0] probe_line_o, bus_line_o;
  logic        bus_busy_i = 1'b1, bus_req_o;
  logic        rsp_valid_i = 1'b0, rsp_fault_i = 1'b0;
  logic [25:0] rsp_line_i = '0, look_line_i = '0;
  logic        look_hit_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stride_prefetcher u0 (.clk_i(clk), .*);

  typedef struct packed {
    logic [31:0] ip;
    logic [31:0] addr;
    logic        hit;
    logic        pv;
    logic [25:0] line;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    // R2: stride 0x40 trains, predicts on the 4th load
    '{32'h100, 32'h1000, 1'b0, 1'b0, 26'h0,   8'd2},
    '{32'h100, 32'h1040, 1'b0, 1'b0, 26'h0,   8'd2},
    '{32'h100, 32'h1080, 1'b0, 1'b0, 26'h0,   8'd2},
    '{32'h100, 32'h10C0, 1'b0, 1'b1, 26'h44,  8'd2},
    // R6: cache already holds the line
    '{32'h100, 32'h1100, 1'b1, 1'b1, 26'h45,  8'd6},
    '{32'h100, 32'h1140, 1'b0, 1'b1, 26'h46,  8'd2},
    // R7: another instruction predicts queued line 0x44
    '{32'h206, 32'h1000, 1'b0, 1'b0, 26'h0,   8'd7},
    '{32'h206, 32'h1040, 1'b0, 1'b0, 26'h0,   8'd7},
    '{32'h206, 32'h1080, 1'b0, 1'b0, 26'h0,   8'd7},
    '{32'h206, 32'h10C0, 1'b0, 1'b1, 26'h44,  8'd7},
    // R4: zero stride
    '{32'h302, 32'h2000, 1'b0, 1'b0, 26'h0,   8'd4},
    '{32'h302, 32'h2000, 1'b0, 1'b0, 26'h0,   8'd4},
    '{32'h302, 32'h2000, 1'b0, 1'b0, 26'h0,   8'd4},
    '{32'h302, 32'h2000, 1'b0, 1'b0, 26'h0,   8'd4},
    // R3: stride change restarts confidence
    '{32'h403, 32'h3000, 1'b0, 1'b0, 26'h0,   8'd3},
    '{32'h403, 32'h3040, 1'b0, 1'b0, 26'h0,   8'd3},
    '{32'h403, 32'h3080, 1'b0, 1'b0, 26'h0,   8'd3},
    '{32'h403, 32'h3100, 1'b0, 1'b0, 26'h0,   8'd3},
    '{32'h403, 32'h3180, 1'b0, 1'b0, 26'h0,   8'd3},
    '{32'h403, 32'h3200, 1'b0, 1'b1, 26'hCA,  8'd3},
    // R13: descending stream
    '{32'h504, 32'h5000, 1'b0, 1'b0, 26'h0,   8'd13},
    '{32'h504, 32'h4FC0, 1'b0, 1'b0, 26'h0,   8'd13},
    '{32'h504, 32'h4F80, 1'b0, 1'b0, 26'h0,   8'd13},
    '{32'h504, 32'h4F40, 1'b0, 1'b1, 26'h13C, 8'd13},
    // R8: queue now full, this one is dropped
    '{32'h607, 32'h8000, 1'b0, 1'b0, 26'h0,   8'd8},
    '{32'h607, 32'h8040, 1'b0, 1'b0, 26'h0,   8'd8},
    '{32'h607, 32'h8080, 1'b0, 1'b0, 26'h0,   8'd8},
    '{32'h607, 32'h80C0, 1'b0, 1'b1, 26'h204, 8'd8}
  };

  task automatic check(int r, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic do_load(logic [31:0] ip, logic [31:0] addr, logic hit,
                         logic pv, logic [25:0] line, int r);
    @(negedge clk);
    ld_valid_i = 1'b1; ld_ip_i = ip; ld_addr_i = addr; probe_hit_i = hit;
    #1;
    check(r, "probe_valid", 32'(probe_valid_o), 32'(pv));
    if (pv) check(r, "probe_line", 32'(probe_line_o), 32'(line));
    @(posedge clk); #1;
    ld_valid_i = 1'b0; probe_hit_i = 1'b0;
  endtask

  task automatic do_rsp(logic [25:0] line, logic fault);
    @(negedge clk);
    rsp_valid_i = 1'b1; rsp_line_i = line; rsp_fault_i = fault;
    @(posedge clk); #1;
    rsp_valid_i = 1'b0; rsp_fault_i = 1'b0;
  endtask

  task automatic look(logic [25:0] line, logic exp, int r);
    @(negedge clk);
    look_line_i = line; #1;
    check(r, "look_hit", 32'(look_hit_o), 32'(exp));
  endtask

  initial begin
    logic [25:0] drain [4] = '{26'h44, 26'h46, 26'hCA, 26'h13C};
    #12;
    // R1: reset state
    check(1, "probe_valid in reset", 32'(probe_valid_o), 32'd0);
    check(1, "bus_req in reset", 32'(bus_req_o), 32'd0);
    rst_ni = 1'b1;
    look(26'h44, 1'b0, 1);

    for (int i = 0; i < NV; i++)
      do_load(VECS[i].ip, VECS[i].addr, VECS[i].hit, VECS[i].pv, VECS[i].line, int'(VECS[i].req));

    // R9: no issue while demand owns the bus
    @(negedge clk); #1;
    check(9, "bus_req while busy", 32'(bus_req_o), 32'd0);

    // R9, R7, R8: drain order shows dup and overflow were dropped
    bus_busy_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      #1;
      check(9, "bus_req drain", 32'(bus_req_o), 32'd1);
      check(7, "bus_line drain", 32'(bus_line_o), 32'(drain[i]));
      @(negedge clk);
    end
    #1;
    check(8, "queue empty after drain", 32'(bus_req_o), 32'd0);

    // R10
    do_rsp(26'h44, 1'b0);
    look(26'h44, 1'b1, 10);
    // R11
    do_rsp(26'hCA, 1'b1);
    look(26'hCA, 1'b0, 11);
    // R12: fifth fill evicts the oldest
    do_rsp(26'h46, 1'b0);
    do_rsp(26'h13C, 1'b0);
    do_rsp(26'h204, 1'b0);
    look(26'h44, 1'b1, 12);
    do_rsp(26'h300, 1'b0);
    look(26'h44, 1'b0, 12);
    look(26'h46, 1'b1, 12);
    look(26'h300, 1'b1, 12);

    // R5: aliasing instruction replaces entry 0
    do_load(32'h110, 32'h9000, 1'b0, 1'b0, 26'h0, 5);
    do_load(32'h100, 32'h1180, 1'b0, 1'b0, 26'h0, 5);

    // R1: reset clears table and buffer
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); #1;
    check(1, "bus_req after reset", 32'(bus_req_o), 32'd0);
    rst_ni = 1'b1;
    look(26'h46, 1'b0, 1);
    do_load(32'h403, 32'h3280, 1'b0, 1'b0, 26'h0, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule